// File: doc/BRIEF.md
# Stereo I2S Master Transmitter with Clock Prescaler

This block sends two-channel audio out of a chip as an I2S master. A free-running peripheral clock is divided by a programmable prescaler to form a master-clock pulse train. From that pulse train the block derives the sample-frame rate and the serial bit clock, then shifts samples out of a small transmit FIFO, most significant bit first, left channel and then right.

An external DMA engine feeds the FIFO through a one-word write port. The block raises a request line while the FIFO runs low, so the DMA engine can refill it before it drains. A small word-addressed register file holds the transmit mode, the prescaler value, the FIFO control bits and the global control bits. Software programs them before starting the stream.

The clock outputs are produced as levels and pulses in the peripheral clock domain. The master clock appears as a one-cycle pulse `mclk_pulse`. The bit clock `bclk` and the word-select line `lrclk` are registered levels.

Top module: `i2s_tx_master`

## Requirements
- R1: `mclk_pulse` is high for one cycle every n+1 peripheral clock cycles, where n is bits [4:0] of the divider register; bits [9:5] of that register have no effect on the timing. While control bit 1 (prescaler enable) is 0, `mclk_pulse`, `bclk`, `lrclk` and `sdata` all stay low.
- R2: Mode bit 2 sets the frame length: 1 gives 384 master-clock pulses per stereo frame, 0 gives 256. `lrclk` repeats once per frame.
- R3: Mode bits [1:0] set the bit clocks per frame: 01 (or 1x) gives 32, 00 gives 16. Each bit period lasts frame/bit-count master clocks, and `bclk` is low in the first half of the period and high in the second.
- R4: `lrclk` is 0 while the left word is sent and 1 while the right word is sent. It changes one bit clock before the MSB of each word. `sdata` and `lrclk` change only where `bclk` falls.
- R5: Mode bit 3 = 1 sends each 16-bit FIFO entry MSB first. Mode bit 3 = 0 sends the entry's low byte MSB first. A word is cut to the channel's slot count (16 bits per channel with 32 bit clocks, 8 bits with 16), and unused slots carry 0.
- R6: The FIFO is 16 entries of 16 bits. Entries leave in write order, alternating left then right, one entry per channel word. A write to a full FIFO is dropped.
- R7: When the FIFO is empty at the start of a channel word, that word is sent as all zeros.
- R8: `dma_req` is 1 exactly when control bit 5, FIFO-control bit 15 and FIFO-control bit 13 are all 1 and the FIFO holds fewer than 8 entries.
- R9: While FIFO-control bit 13 is 0, the FIFO is emptied and DMA writes are ignored.
- R10: Unless mode bits [7:6] = 10 (transmit), no entry is taken from the FIFO and `sdata` stays 0.
- R11: Registers are word addresses 0 = mode (bits [9:0] kept), 1 = control (bits 5 and 1 kept), 2 = divider (bits [9:0] kept), 3 = FIFO control (bits 15 and 13 kept). Bits that are not kept read as 0, and all registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register word address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_addr` |
| dma_we | input | 1 | DMA write strobe into the FIFO |
| dma_data | input | 16 | DMA sample word |
| dma_req | output | 1 | DMA service request |
| mclk_pulse | output | 1 | One-cycle master-clock pulse |
| bclk | output | 1 | Serial bit clock |
| lrclk | output | 1 | Word select, 0 = left |
| sdata | output | 1 | Serial data |

## Verification
The bench builds the block with its default parameters: a 16-deep, 16-bit FIFO with a low-water mark of 8. With these values the DMA threshold and the full-FIFO drop can each be reached with a handful of writes. The divider is set to small values (0, 1, 3), so 384- and 256-clock frames complete in a few hundred cycles. This keeps all three slot/width combinations, the zero-fill after the FIFO drains and the 20-write overflow within a short run.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;
  localparam logic [1:0] ADDR_FIFO = 2'd3;

  localparam logic [15:0] MODE_KEEP = 16'h03FF;
  localparam logic [15:0] CTRL_KEEP = 16'h0022;
  localparam logic [15:0] DIV_KEEP  = 16'h03FF;
  localparam logic [15:0] FIFO_KEEP = 16'hA000;

  // master clocks per serial bit: frame length divided by bits per frame
  function automatic logic [4:0] bit_period(input logic long_frame, input logic wide_slots);
    logic [4:0] p;
    case ({long_frame, wide_slots})
      2'b11:   p = 5'd12;
      2'b10:   p = 5'd24;
      2'b01:   p = 5'd8;
      default: p = 5'd16;
    endcase
    return p;
  endfunction

  // serial slots per channel
  function automatic logic [4:0] half_slots(input logic wide_slots);
    return wide_slots ? 5'd16 : 5'd8;
  endfunction
endpackage

// File: rtl/i2s_tx_regs.sv
module i2s_tx_regs
  import i2s_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [1:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic [4:0]  div_n,
  output logic        long_frame,
  output logic        wide_slots,
  output logic        wide_data,
  output logic        tx_mode,
  output logic        presc_en,
  output logic        dreq_en,
  output logic        fifo_en,
  output logic        fifo_dma
);
  logic [15:0] mode_q, ctrl_q, div_q, fifo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ctrl_q <= '0;
      div_q  <= '0;
      fifo_q <= '0;
    end else if (wr) begin
      case (addr)
        ADDR_MODE: mode_q <= wdata & MODE_KEEP;
        ADDR_CTRL: ctrl_q <= wdata & CTRL_KEEP;
        ADDR_DIV:  div_q  <= wdata & DIV_KEEP;
        default:   fifo_q <= wdata & FIFO_KEEP;
      endcase
    end
  end

  always_comb begin
    case (addr)
      ADDR_MODE: rdata = mode_q;
      ADDR_CTRL: rdata = ctrl_q;
      ADDR_DIV:  rdata = div_q;
      default:   rdata = fifo_q;
    endcase
  end

  assign div_n      = div_q[4:0];
  assign long_frame = mode_q[2];
  assign wide_slots = mode_q[1] | mode_q[0];
  assign wide_data  = mode_q[3];
  assign tx_mode    = (mode_q[7:6] == 2'b10);
  assign presc_en   = ctrl_q[1];
  assign dreq_en    = ctrl_q[5];
  assign fifo_en    = fifo_q[13];
  assign fifo_dma   = fifo_q[15];
endmodule

// File: rtl/i2s_tx_prescaler.sv
module i2s_tx_prescaler #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_n,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt >= div_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!en)   cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          push_ok,
  output logic          pop_ok
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  assign push_ok = push && (count < CW'(DEPTH));
  assign pop_ok  = pop && (count != '0);
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push_ok) wp <= step(wp);
      if (pop_ok)  rp <= step(rp);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
  import i2s_tx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         long_frame,
  input  logic         wide_slots,
  input  logic         wide_data,
  input  logic         tx_mode,
  input  logic         has_data,
  input  logic [W-1:0] word_in,
  output logic         pop,
  output logic         slot_start,
  output logic         bclk,
  output logic         lrclk,
  output logic         sdata
);
  logic [4:0]   pcnt, bcnt, bnext, period, half, last_slot;
  logic [W-1:0] shreg, fresh;
  logic         load_slot, ws_q, sd_q;

  assign period    = bit_period(long_frame, wide_slots);
  assign half      = half_slots(wide_slots);
  assign last_slot = {half[3:0], 1'b0} - 5'd1;
  assign slot_start = tick && (pcnt >= period - 5'd1);
  assign bnext     = (bcnt >= last_slot) ? 5'd0 : bcnt + 5'd1;
  assign load_slot = (bnext == 5'd1) || (bnext == half + 5'd1);
  assign pop       = slot_start && load_slot && tx_mode && has_data;

  always_comb begin
    if (!tx_mode || !has_data) fresh = '0;
    else if (wide_data)        fresh = word_in;
    else                       fresh = {word_in[7:0], {(W-8){1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0; bcnt <= '0; shreg <= '0; ws_q <= 1'b0; sd_q <= 1'b0;
    end else if (!run) begin
      pcnt <= '0; bcnt <= '0; shreg <= '0; ws_q <= 1'b0; sd_q <= 1'b0;
    end else if (slot_start) begin
      pcnt <= '0;
      bcnt <= bnext;
      ws_q <= (bnext >= half);
      if (load_slot) begin
        shreg <= {fresh[W-2:0], 1'b0};
        sd_q  <= tx_mode & fresh[W-1];
      end else begin
        shreg <= {shreg[W-2:0], 1'b0};
        sd_q  <= tx_mode & shreg[W-1];
      end
    end else if (tick) begin
      pcnt <= pcnt + 5'd1;
    end
  end

  assign bclk  = run && (pcnt >= {1'b0, period[4:1]});
  assign lrclk = ws_q;
  assign sdata = sd_q;
endmodule

// File: rtl/i2s_tx_master.sv
module i2s_tx_master
  import i2s_tx_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int LOW_WATER  = 8,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              dma_we,
  input  logic [DATA_W-1:0] dma_data,
  output logic              dma_req,
  output logic              mclk_pulse,
  output logic              bclk,
  output logic              lrclk,
  output logic              sdata
);
  logic [4:0]        div_n;
  logic              long_frame, wide_slots, wide_data, tx_mode;
  logic              presc_en, dreq_en, fifo_en, fifo_dma;
  logic [DATA_W-1:0] fifo_dout;
  logic [CNT_W-1:0]  fifo_count;
  logic              fifo_push, fifo_push_ok, fifo_pop_req, fifo_pop;
  logic              slot_start;

  i2s_tx_regs regs_i (
    .clk, .rst_n, .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .div_n, .long_frame, .wide_slots, .wide_data, .tx_mode,
    .presc_en, .dreq_en, .fifo_en, .fifo_dma
  );

  i2s_tx_prescaler #(.DIV_W(5)) presc_i (
    .clk, .rst_n, .en(presc_en), .div_n, .tick(mclk_pulse)
  );

  assign fifo_push = dma_we && fifo_en;

  i2s_tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk, .rst_n, .clr(!fifo_en), .push(fifo_push), .din(dma_data),
    .pop(fifo_pop_req), .dout(fifo_dout), .count(fifo_count),
    .push_ok(fifo_push_ok), .pop_ok(fifo_pop)
  );

  i2s_tx_serializer #(.W(DATA_W)) ser_i (
    .clk, .rst_n, .run(presc_en), .tick(mclk_pulse),
    .long_frame, .wide_slots, .wide_data, .tx_mode,
    .has_data(fifo_count != '0), .word_in(fifo_dout),
    .pop(fifo_pop_req), .slot_start, .bclk, .lrclk, .sdata
  );

  assign dma_req = dreq_en && fifo_dma && fifo_en && (fifo_count < CNT_W'(LOW_WATER));
endmodule

// File: rtl/i2s_tx_checker.sv
module i2s_tx_checker #(
  parameter int DEPTH     = 16,
  parameter int LOW_WATER = 8,
  parameter int CNT_W     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic [4:0]       div_n,
  input logic             mclk_pulse,
  input logic             bclk,
  input logic             lrclk,
  input logic             sdata,
  input logic             fifo_en,
  input logic             tx_mode,
  input logic             fifo_push,
  input logic             fifo_pop,
  input logic [CNT_W-1:0] fifo_count,
  input logic             dma_req
);
  logic [6:0] gap;
  logic       gap_valid;
  logic [4:0] div_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0; gap_valid <= 1'b0; div_d <= '0;
    end else begin
      div_d <= div_n;
      if (!run || div_n != div_d) begin
        gap <= '0; gap_valid <= 1'b0;
      end else if (mclk_pulse) begin
        gap <= 7'd1; gap_valid <= 1'b1;
      end else if (gap != 7'h7F) begin
        gap <= gap + 7'd1;
      end
    end
  end

  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mclk_pulse && gap_valid && run && div_n == div_d) |-> (gap == {2'b00, div_n} + 7'd1));

  p_quiet_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!lrclk && !sdata));

  p_sd_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(sdata)) |-> $fell(bclk));

  p_ws_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(lrclk)) |-> $fell(bclk));

  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && fifo_push && !fifo_pop && fifo_count == CNT_W'(DEPTH)) |=> (fifo_count == CNT_W'(DEPTH)));

  p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (fifo_count != '0));

  p_req_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count >= CNT_W'(LOW_WATER)) |-> !dma_req);

  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> (fifo_count == '0));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_mode |-> !fifo_pop);
endmodule

bind i2s_tx_master i2s_tx_checker #(
  .DEPTH(FIFO_DEPTH), .LOW_WATER(LOW_WATER), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .run(presc_en), .div_n(div_n),
  .mclk_pulse(mclk_pulse), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
  .fifo_en(fifo_en), .tx_mode(tx_mode), .fifo_push(fifo_push),
  .fifo_pop(fifo_pop), .fifo_count(fifo_count), .dma_req(dma_req)
);

// File: tb/i2s_tx_master_tb_top.sv
module i2s_tx_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic [15:0] cfg_rdata;
  logic        dma_we = 1'b0;
  logic [15:0] dma_data = 16'd0;
  logic        dma_req, mclk_pulse, bclk, lrclk, sdata;

  int errors = 0;
  int checks = 0;

  always #4ns clk = ~clk;

  i2s_tx_master dut_i (
    .clk, .rst_n, .cfg_wr, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .dma_we, .dma_data, .dma_req, .mclk_pulse, .bclk, .lrclk, .sdata
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1ns;
    d = cfg_rdata;
  endtask

  // scoreboard ------------------------------------------------------------
  logic [15:0] exp_q[$];
  bit          cur_w16, cur_h16;
  string       cur_req = "R5";

  // word as it appears on the wire, left-aligned: width rule then slot cut
  function automatic logic [15:0] wire_word(input logic [15:0] d, input bit w16, input bit h16);
    logic [15:0] v;
    v = w16 ? d : {d[7:0], 8'h00};
    if (!h16) v = {v[15:8], 8'h00};
    return v;
  endfunction

  task automatic push_sample(input logic [15:0] d, input bit expect_kept);
    @(negedge clk);
    dma_data = d; dma_we = 1'b1;
    @(negedge clk);
    dma_we = 1'b0;
    if (expect_kept) exp_q.push_back(wire_word(d, cur_w16, cur_h16));
  endtask

  // monitor ---------------------------------------------------------------
  bit          mon_on = 1'b0;
  bit          prev_sclk, prev_ws, collecting;
  int          idx, words_done, cyc, last_b, last_f, bper, fper, nb, nf;
  logic [15:0] word;

  task automatic start_mon();
    prev_sclk = 1'b0; prev_ws = 1'b1; collecting = 1'b0;
    idx = 0; words_done = 0; nb = 0; nf = 0; bper = 0; fper = 0;
    mon_on = 1'b1;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (bclk && !prev_sclk) begin
        if (nb > 0) bper = cyc - last_b;
        last_b = cyc; nb++;
        if (collecting) begin
          word[15-idx] = sdata;
          idx++;
          if (idx == (cur_h16 ? 16 : 8)) begin
            logic [15:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'h0000;
            check(cur_req, $sformatf("word %0d", words_done), int'(word), int'(e));
            collecting = 1'b0;
            words_done++;
          end
        end
        if (lrclk != prev_ws) begin
          if (!lrclk) begin
            if (nf > 0) fper = cyc - last_f;
            last_f = cyc; nf++;
          end
          collecting = 1'b1; idx = 0; word = '0;
        end
        prev_ws = lrclk;
      end
      prev_sclk = bclk;
    end
  end

  task automatic wait_words(input int n);
    int t = 0;
    while (words_done < n && t < 20000) begin
      @(negedge clk); t++;
    end
    check(cur_req, "words received", words_done, n);
  endtask

  task automatic reset_fifo();
    write_reg(2'd1, 16'h0000);
    write_reg(2'd3, 16'h0000);
    write_reg(2'd3, 16'hA000);
    exp_q.delete();
  endtask

  task automatic run_stream(input logic [15:0] mode, input logic [15:0] divr,
                            input int nsamp, input int nwords, input int exp_b,
                            input int exp_f, input string req);
    cur_w16 = mode[3]; cur_h16 = (mode[1:0] != 2'b00); cur_req = req;
    reset_fifo();
    write_reg(2'd0, mode);
    write_reg(2'd2, divr);
    for (int i = 0; i < nsamp; i++)
      push_sample(16'hA5C3 ^ 16'(i * 16'h1357), i < 16);
    start_mon();
    write_reg(2'd1, 16'h0022);
    wait_words(nwords);
    check("R3", "bit clock period", bper, exp_b);
    check("R2", "frame period", fper, exp_f);
    mon_on = 1'b0;
    write_reg(2'd1, 16'h0000);
  endtask

  int cnt;
  logic [15:0] rd;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    read_reg(2'd0, rd); check("R11", "mode reset", rd, 0);
    read_reg(2'd1, rd); check("R11", "ctrl reset", rd, 0);
    read_reg(2'd2, rd); check("R11", "div reset", rd, 0);
    read_reg(2'd3, rd); check("R11", "fifo reset", rd, 0);
    check("R1", "outputs quiet at reset", {dma_req, mclk_pulse, bclk, lrclk, sdata}, 0);

    // register map and kept bits
    write_reg(2'd1, 16'hFFFF); read_reg(2'd1, rd); check("R11", "ctrl kept bits", rd, 16'h0022);
    write_reg(2'd3, 16'hFFFF); read_reg(2'd3, rd); check("R11", "fifo kept bits", rd, 16'hA000);
    write_reg(2'd0, 16'hFFFF); read_reg(2'd0, rd); check("R11", "mode kept bits", rd, 16'h03FF);
    write_reg(2'd1, 16'h0000); write_reg(2'd3, 16'h0000); write_reg(2'd0, 16'h0000);

    // prescaler: high field 7 ignored, low field 1 -> every 2 cycles
    write_reg(2'd2, 16'h00E1); read_reg(2'd2, rd); check("R11", "div readback", rd, 16'h00E1);
    write_reg(2'd1, 16'h0002);
    cnt = 0; for (int i = 0; i < 64; i++) begin @(negedge clk); cnt += mclk_pulse; end
    check("R1", "pulses in 64 cycles, n=1", cnt, 32);
    write_reg(2'd2, 16'h0003);
    repeat (4) @(negedge clk);
    cnt = 0; for (int i = 0; i < 64; i++) begin @(negedge clk); cnt += mclk_pulse; end
    check("R1", "pulses in 64 cycles, n=3", cnt, 16);
    write_reg(2'd1, 16'h0000);
    cnt = 0; for (int i = 0; i < 64; i++) begin @(negedge clk); cnt += mclk_pulse + bclk + lrclk + sdata; end
    check("R1", "quiet while prescaler off", cnt, 0);

    // DMA request and FIFO control (prescaler off so nothing drains)
    write_reg(2'd0, 16'h008D);
    write_reg(2'd3, 16'hA000); write_reg(2'd1, 16'h0020);
    @(negedge clk); check("R8", "request when empty", dma_req, 1);
    for (int i = 0; i < 7; i++) push_sample(16'(i), 1'b0);
    check("R8", "request at 7 entries", dma_req, 1);
    push_sample(16'h0007, 1'b0);
    check("R8", "no request at 8 entries", dma_req, 0);
    write_reg(2'd3, 16'h0000); write_reg(2'd3, 16'hA000);
    @(negedge clk); check("R9", "flush re-raises request", dma_req, 1);
    write_reg(2'd3, 16'h2000);
    @(negedge clk); check("R8", "no request without DMA select", dma_req, 0);
    write_reg(2'd3, 16'hA000); write_reg(2'd1, 16'h0000);
    @(negedge clk); check("R8", "no request without enable", dma_req, 0);
    write_reg(2'd1, 16'h0020); write_reg(2'd3, 16'h0000);
    for (int i = 0; i < 8; i++) push_sample(16'(i), 1'b0);
    write_reg(2'd3, 16'hA000);
    @(negedge clk); check("R9", "writes ignored while disabled", dma_req, 1);
    write_reg(2'd1, 16'h0000);

    // streams: 16-bit/384/32, 8-bit/256/32 with n=1, 16-bit/384/16
    run_stream(16'h008D, 16'h0000, 6, 8, 12, 384, "R5_R7");
    run_stream(16'h0081, 16'h0001, 4, 5, 16, 512, "R5");
    run_stream(16'h008C, 16'h0000, 4, 5, 24, 384, "R4_R5");
    // overflow: 20 writes, 16 kept, then zeros
    run_stream(16'h008D, 16'h0000, 20, 18, 12, 384, "R6");

    // non-transmit mode: no pops, data low
    reset_fifo();
    write_reg(2'd0, 16'h000D); write_reg(2'd2, 16'h0000);
    for (int i = 0; i < 8; i++) push_sample(16'hFFFF, 1'b0);
    write_reg(2'd1, 16'h0022);
    cnt = 0; for (int i = 0; i < 2000; i++) begin @(negedge clk); cnt += sdata; end
    check("R10", "data low outside transmit", cnt, 0);
    check("R10", "FIFO untouched outside transmit", dma_req, 0);
    write_reg(2'd1, 16'h0000);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8ns * 190000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule